// File: doc/BRIEF.md
# Serial Servo Command PWM Controller

This block turns a stream of received bytes into the pulse trains that position four hobby servos. Each command is two bytes long: a lower-case letter naming a joint, then a position byte. The block decodes the letter, stores the position as the new target of that joint, and drives four PWM outputs that share one fixed frame. A byte strobe with data arrives from a serial receiver outside the block.

Every output goes high at the start of each frame and stays high for a time that grows linearly with the stored position. Position 0 gives a 1 ms pulse and position 255 a 2 ms pulse, so the whole byte range covers the servo's full mechanical travel. The frame lasts 20 ms. All times are derived from the clock-frequency parameter, and a new target is taken up only when a frame begins, so a pulse is never cut short or stretched while it is being driven.

Top module: `servo_cmd_pwm`

## Requirements
- R1: The identifier bytes 8'h6C ('l'), 8'h72 ('r'), 8'h74 ('t') and 8'h70 ('p') select output bits pwm_o[0], pwm_o[1], pwm_o[2] and pwm_o[3] respectively.
- R2: The byte that follows an accepted identifier is always taken as the position, whatever its value, even when it equals an identifier code; the block then waits for an identifier again.
- R3: While the block waits for an identifier, any byte other than the four codes of R1 (upper-case letters included) is discarded and changes no output; the next byte is again decoded as an identifier.
- R4: The high time of a pulse, in clock cycles, is CLK_HZ/1000 + floor(pos * (CLK_HZ/1000) / 255), where pos is the 8-bit position.
- R5: The frame lasts CLK_HZ/50 cycles; all four outputs rise in the same cycle at each frame start, and the first rise follows the first clock edge after reset is released.
- R6: A position accepted while a pulse is being driven does not alter that pulse; it governs the pulse of the next frame.
- R7: A position byte accepted at the clock edge that closes a frame governs the pulse that starts right after that edge; one accepted one edge later waits for the following frame.
- R8: During reset all outputs are low, and after reset every joint holds position 128.
- R9: A command changes the pulse width of its own output only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of frequency CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid_i | input | 1 | One-cycle strobe marking a received byte |
| rx_data_i | input | 8 | Received byte, valid with rx_valid_i |
| pwm_o | output | 4 | Servo pulse outputs, bit index per R1 |

## Verification
The two functions that can meet in one cycle are the storing of a new position and the frame-start capture of the width that the next pulse will use. The bench locks onto a rising pulse edge to know the frame phase, then delivers a position byte exactly at the closing edge of a frame and, in a second run, one edge later. The first case must show the new width in the very next pulse, the second must show the old width once more and the new width one frame after.

// File: rtl/servo_pkg.sv
package servo_pkg;

    localparam int unsigned CH_NUM = 4;
    localparam int unsigned CH_W   = 2;

    typedef logic [7:0] pos_t;
    localparam pos_t POS_CENTRE = 8'd128;

    localparam logic [7:0] ID_LEFT  = 8'h6C;
    localparam logic [7:0] ID_RIGHT = 8'h72;
    localparam logic [7:0] ID_TILT  = 8'h74;
    localparam logic [7:0] ID_PAN   = 8'h70;

    typedef enum logic {
        PS_ID  = 1'b0,
        PS_POS = 1'b1
    } parse_st_e;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
    } id_dec_t;

    typedef struct packed {
        logic            en;
        logic [CH_W-1:0] ch;
        pos_t            pos;
    } tgt_wr_t;

    function automatic id_dec_t decode_id(input logic [7:0] b);
        id_dec_t d;
        d.hit = 1'b1;
        d.ch  = '0;
        case (b)
            ID_LEFT:  d.ch = 2'd0;
            ID_RIGHT: d.ch = 2'd1;
            ID_TILT:  d.ch = 2'd2;
            ID_PAN:   d.ch = 2'd3;
            default:  d.hit = 1'b0;
        endcase
        return d;
    endfunction

    // Linear map of a position onto a pulse length in cycles.
    function automatic int unsigned pos_to_width(input pos_t p,
                                                 input int unsigned min_c,
                                                 input int unsigned span_c);
        return min_c + ((32'(p) * span_c) / 32'd255);
    endfunction

endpackage

// File: rtl/servo_cmd_parser.sv
module servo_cmd_parser
    import servo_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rx_valid_i,
    input  logic [7:0] rx_data_i,
    output tgt_wr_t wr_o
);

    parse_st_e       state_q;
    logic [CH_W-1:0] ch_q;
    id_dec_t         dec;

    always_comb dec = decode_id(rx_data_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_ID;
            ch_q    <= '0;
        end else if (rx_valid_i) begin
            case (state_q)
                PS_ID: begin
                    if (dec.hit) begin
                        state_q <= PS_POS;
                        ch_q    <= dec.ch;
                    end
                end
                default: state_q <= PS_ID;
            endcase
        end
    end

    always_comb begin
        wr_o.en  = rx_valid_i && (state_q == PS_POS);
        wr_o.ch  = ch_q;
        wr_o.pos = rx_data_i;
    end

endmodule

// File: rtl/servo_target_bank.sv
module servo_target_bank
    import servo_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  tgt_wr_t                 wr_i,
    output logic [CH_NUM-1:0][7:0]  tgt_q_o,
    output logic [CH_NUM-1:0][7:0]  tgt_nx_o
);

    for (genvar i = 0; i < CH_NUM; i++) begin : g_slot
        logic sel;
        assign sel = wr_i.en && (wr_i.ch == CH_W'(i));

        always_ff @(posedge clk) begin
            if (rst)      tgt_q_o[i] <= POS_CENTRE;
            else if (sel) tgt_q_o[i] <= wr_i.pos;
        end

        // Forward a write landing in the same cycle as the frame capture.
        always_comb tgt_nx_o[i] = sel ? wr_i.pos : tgt_q_o[i];
    end

endmodule

// File: rtl/servo_frame_timer.sv
module servo_frame_timer #(
    parameter int unsigned PERIOD_CYC = 1000000,
    parameter int unsigned CNT_W      = 20
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

    always_comb last_o = (cnt_o == LAST);

    always_ff @(posedge clk) begin
        if (rst)         cnt_o <= '0;
        else if (last_o) cnt_o <= '0;
        else             cnt_o <= cnt_o + 1'b1;
    end

endmodule

// File: rtl/servo_pwm_lane.sv
module servo_pwm_lane
    import servo_pkg::*;
#(
    parameter int unsigned CNT_W  = 20,
    parameter int unsigned MIN_C  = 50000,
    parameter int unsigned SPAN_C = 50000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             last_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  pos_t             tgt_nx_i,
    output logic [CNT_W-1:0] act_w_o,
    output logic             pwm_o
);

    localparam logic [CNT_W-1:0] RST_W = CNT_W'(pos_to_width(POS_CENTRE, MIN_C, SPAN_C));

    logic [CNT_W-1:0] nx_w;
    always_comb nx_w = CNT_W'(pos_to_width(tgt_nx_i, MIN_C, SPAN_C));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_w_o <= RST_W;
            pwm_o   <= 1'b0;
        end else begin
            if (last_i) act_w_o <= nx_w;
            pwm_o <= (cnt_i < act_w_o);
        end
    end

endmodule

// File: rtl/servo_cmd_pwm.sv
module servo_cmd_pwm
    import servo_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_data_i,
    output logic [CH_NUM-1:0] pwm_o
);

    localparam int unsigned PERIOD_CYC = CLK_HZ / 50;
    localparam int unsigned MIN_CYC    = CLK_HZ / 1000;
    localparam int unsigned SPAN_CYC   = CLK_HZ / 1000;
    localparam int unsigned MAX_CYC    = MIN_CYC + SPAN_CYC;
    localparam int unsigned CNT_W      = $clog2(PERIOD_CYC);

    tgt_wr_t                         wr;
    logic [CH_NUM-1:0][7:0]          tgt_q;
    logic [CH_NUM-1:0][7:0]          tgt_nx;
    logic [CNT_W-1:0]                cnt_q;
    logic                            frame_last;
    logic [CH_NUM-1:0][CNT_W-1:0]    act_w;

    servo_cmd_parser u_parser (
        .clk        (clk),
        .rst        (rst),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .wr_o       (wr)
    );

    servo_target_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (wr),
        .tgt_q_o  (tgt_q),
        .tgt_nx_o (tgt_nx)
    );

    servo_frame_timer #(
        .PERIOD_CYC (PERIOD_CYC),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt_q),
        .last_o (frame_last)
    );

    for (genvar i = 0; i < CH_NUM; i++) begin : g_lane
        servo_pwm_lane #(
            .CNT_W  (CNT_W),
            .MIN_C  (MIN_CYC),
            .SPAN_C (SPAN_CYC)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .last_i   (frame_last),
            .cnt_i    (cnt_q),
            .tgt_nx_i (tgt_nx[i]),
            .act_w_o  (act_w[i]),
            .pwm_o    (pwm_o[i])
        );
    end

endmodule

// File: rtl/servo_cmd_pwm_chk.sv
module servo_cmd_pwm_chk
    import servo_pkg::*;
#(
    parameter int unsigned PERIOD_CYC = 1000000,
    parameter int unsigned MAX_CYC    = 100000,
    parameter int unsigned CNT_W      = 20
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         rx_valid_i,
    input logic [CH_NUM-1:0]            pwm_o,
    input logic [CNT_W-1:0]             cnt_q,
    input logic [CH_NUM-1:0][CNT_W-1:0] act_w,
    input logic [CH_NUM-1:0][7:0]       tgt_q,
    input tgt_wr_t                      wr
);

    p_frame_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q == CNT_W'(PERIOD_CYC - 1) |=> cnt_q == '0);

    for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
        p_rise_at_start_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(pwm_o[i]) |-> cnt_q == CNT_W'(1));
    end

    p_width_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q != '0 |-> $stable(act_w));

    p_high_bounded_r4: assert property (@(posedge clk) disable iff (rst)
        pwm_o != '0 |-> cnt_q <= CNT_W'(MAX_CYC));

    p_targets_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(tgt_q));

    p_write_needs_byte_r2: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> rx_valid_i);

    p_no_back_to_back_r2: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> !wr.en);

    p_low_out_of_reset_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pwm_o == '0);

endmodule

bind servo_cmd_pwm servo_cmd_pwm_chk #(
    .PERIOD_CYC (PERIOD_CYC),
    .MAX_CYC    (MAX_CYC),
    .CNT_W      (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid_i (rx_valid_i),
    .pwm_o      (pwm_o),
    .cnt_q      (cnt_q),
    .act_w      (act_w),
    .tgt_q      (tgt_q),
    .wr         (wr)
);

// File: tb/servo_cmd_pwm_bench.sv
module servo_cmd_pwm_bench;

    localparam int CLK_HZ = 255000;
    localparam int P      = CLK_HZ / 50;
    localparam int MINW   = CLK_HZ / 1000;
    localparam int SPANW  = CLK_HZ / 1000;

    // {expected channel[1:0], identifier byte, position byte}
    localparam logic [17:0] VEC [6] = '{
        {2'd0, 8'h6C, 8'd0},
        {2'd1, 8'h72, 8'd255},
        {2'd2, 8'h74, 8'd77},
        {2'd3, 8'h70, 8'd200},
        {2'd0, 8'h6C, 8'd128},
        {2'd3, 8'h70, 8'd1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_data_i = 8'h00;
    logic [3:0] pwm_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    int mdl [4];
    int wmeas [4];

    always #10 clk = ~clk;

    servo_cmd_pwm #(.CLK_HZ(CLK_HZ)) u_servo_cmd_pwm (
        .clk        (clk),
        .rst        (rst),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .pwm_o      (pwm_o)
    );

    function automatic int expw(input int p);
        return MINW + (p * SPANW) / 255;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_data_i  = b;
        rx_valid_i = 1'b1;
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    task automatic wait_rise();
        while (pwm_o[0])  @(negedge clk);
        while (!pwm_o[0]) @(negedge clk);
    endtask

    task automatic count_window();
        for (int c = 0; c < 4; c++) wmeas[c] = 0;
        for (int k = 0; k < P - 3; k++) begin
            for (int c = 0; c < 4; c++) if (pwm_o[c]) wmeas[c]++;
            @(negedge clk);
        end
    endtask

    task automatic measure_period();
        wait_rise();
        count_window();
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < 4; c++)
            chk(wmeas[c] == expw(mdl[c]), tag, wmeas[c], expw(mdl[c]));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int n;
        int w;
        for (int c = 0; c < 4; c++) mdl[c] = 128;

        // R8: outputs low while reset is held
        repeat (5) @(negedge clk);
        chk(pwm_o == 4'h0, "R8 low in reset", int'(pwm_o), 0);
        rst = 1'b0;
        @(negedge clk);
        // R5: first rise right after the first edge out of reset
        chk(pwm_o == 4'hF, "R5 first rise", int'(pwm_o), 15);
        count_window();
        check_all("R8 R4 centre after reset");

        // R5: frame length from rise to rise
        wait_rise();
        n = 0;
        while (pwm_o[0])  begin @(negedge clk); n++; end
        while (!pwm_o[0]) begin @(negedge clk); n++; end
        chk(n == P, "R5 frame length", n, P);

        // R1 R4 R9: table of commands
        for (int v = 0; v < 6; v++) begin
            wait_rise();
            send_byte(VEC[v][15:8]);
            send_byte(VEC[v][7:0]);
            mdl[VEC[v][17:16]] = int'(VEC[v][7:0]);
            measure_period();
            for (int c = 0; c < 4; c++) begin
                if (c == int'(VEC[v][17:16]))
                    chk(wmeas[c] == expw(mdl[c]), "R1 R4 addressed width", wmeas[c], expw(mdl[c]));
                else
                    chk(wmeas[c] == expw(mdl[c]), "R9 other width kept", wmeas[c], expw(mdl[c]));
            end
        end

        // R3: non-identifiers discarded, then next byte still decoded as identifier
        wait_rise();
        send_byte(8'h4C);
        send_byte(8'h00);
        send_byte(8'h78);
        measure_period();
        check_all("R3 ignored bytes");
        wait_rise();
        send_byte(8'h78);
        send_byte(8'h74);
        send_byte(8'd50);
        mdl[2] = 50;
        measure_period();
        check_all("R3 identifier after junk");

        // R2: position byte equal to an identifier code
        wait_rise();
        send_byte(8'h72);
        send_byte(8'h6C);
        mdl[1] = 108;
        measure_period();
        check_all("R2 position equals id code");

        // R6: command during a driven pulse leaves that pulse alone
        wait_rise();
        w = 0;
        for (int k = 0; k < P - 3; k++) begin
            if (pwm_o[3]) w++;
            if (k == 0) begin rx_data_i = 8'h70; rx_valid_i = 1'b1; end
            if (k == 1) rx_data_i = 8'd30;
            if (k == 2) rx_valid_i = 1'b0;
            @(negedge clk);
        end
        chk(w == expw(mdl[3]), "R6 pulse in flight keeps width", w, expw(mdl[3]));
        mdl[3] = 30;
        measure_period();
        check_all("R6 new width next frame");

        // R7: position accepted at the closing edge of a frame
        wait_rise();
        send_byte(8'h6C);
        repeat (P - 3) @(negedge clk);
        send_byte(8'd250);
        mdl[0] = 250;
        measure_period();
        chk(wmeas[0] == expw(250), "R7 closing edge write used at once", wmeas[0], expw(250));

        // R7: one edge later it waits a frame
        wait_rise();
        send_byte(8'h6C);
        repeat (P - 2) @(negedge clk);
        send_byte(8'd10);
        w = 0;
        while (pwm_o[0]) begin w++; @(negedge clk); end
        chk(w == expw(250), "R7 late write keeps old width", w, expw(250));
        mdl[0] = 10;
        measure_period();
        check_all("R7 late write next frame");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule